// File: doc/BRIEF.md
# Timer Register Front End with Atomic Alias Windows

This block is the word-addressed register front end of a small timer peripheral. It decodes a byte address and serves reads and writes to the timer's registers: version, enable, software reset, lock, status, configuration, command, counter, top-level busy flags, interrupt flags and enables, group control, two compare values, the capture value and group busy flags. The counter datapath sits outside the block. That datapath supplies the live counter value, the capture value, a running indication and interrupt events. In return it receives the configuration, compare values, control bits and one-cycle command pulses.

The register space is mapped four times. The base window holds plain registers. Three alias windows modify a register atomically: the set window ORs the write data in, the clear window removes the bits set in the data, and the toggle window inverts them. Each of these operations is applied to the value that a read of the register returns. A 16-bit key guards the configuration, group control, compare and counter registers. Enable, software reset and every synchronisation-sensitive write raise a busy flag for a fixed, parameterised number of cycles.

Top module: `tmrf_regfront`

## Requirements
- R1: Address bits [13:12] select the window: 0 is base, 1 is set, 2 is clear, 3 is toggle. Bits [11:2] select the word. A read in any window returns the base value of the word. Unmapped or misaligned (bits [1:0] not zero) addresses read zero and take no write. Word offsets: version 0x000, enable 0x004, soft reset 0x008, lock 0x00C, status 0x010, config 0x014, command 0x018, counter 0x01C, top busy 0x020, flags 0x040, flag enable 0x044, group control 0x048, compare A 0x04C, compare B 0x050, capture 0x054, group busy 0x058.
- R2: A write to the set window stores old|data, the clear window stores old&~data, and the toggle window stores old^data. Here old is the value the register reads back.
- R3: The version word reads 1. Writes to it in any window have no effect.
- R4: The lock word takes a 16-bit key in bits [15:0]. The result 0x4776 unlocks and any other result locks. Status bit 1 reads 1 while locked, and status bit 0 mirrors the running input. The block leaves reset unlocked.
- R5: While locked, writes to config (bit 0), group control (11 bits), compare A, compare B and counter are dropped and raise no busy flag. While unlocked, they take effect.
- R6: Enable bit 0 drives the module-enable output. A write that changes enable from 1 to 0 sets read-only enable bit 1 ("disabling") for BUSY_CYC cycles.
- R7: A soft-reset write whose resulting bit 0 is 1 clears every register and busy flag except the lock state. It then holds read-only soft-reset bit 1 ("resetting") for BUSY_CYC cycles.
- R8: A command write pulses the start output for one cycle when bit 0 is set and the stop output when bit 1 is set. Reads of the command word return zero. An accepted counter write pulses the load output with the written value. Top busy bit 0 (start), bit 1 (stop) and bit 2 (counter write) each hold for BUSY_CYC cycles.
- R9: Accepted writes to group control, compare A and compare B set group busy bit 0, bit 1 and bit 2 respectively, each for BUSY_CYC cycles.
- R10: Each event input bit sets the matching flag bit. Software writes the flags through any window. The interrupt output is high when any flag bit is set together with its enable bit.
- R11: After reset every register reads zero except the version word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 14 | Byte address, window in [13:12] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cnt_value_i | input | 32 | Live counter value from the datapath |
| cap_value_i | input | 32 | Captured counter value from the datapath |
| running_i | input | 1 | Counter running indication |
| evt_i | input | 4 | Interrupt event strobes |
| mod_en_o | output | 1 | Module enable |
| config_o | output | 1 | Configuration bit |
| grp_ctrl_o | output | 11 | Group control field |
| cmpa_o | output | 32 | Compare A value |
| cmpb_o | output | 32 | Compare B value |
| start_pulse_o | output | 1 | One-cycle start command |
| stop_pulse_o | output | 1 | One-cycle stop command |
| cnt_load_o | output | 1 | One-cycle counter load strobe |
| cnt_load_data_o | output | 32 | Value to load into the counter |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the alias arithmetic on a register with mixed bits. A design that applied the operation to the write data alone, or to the wrong window, would leave the compare value wrong after the set, clear and toggle writes. It also checks that the unlock key still works when it arrives through the toggle window, that writes to protected registers are dropped while locked, and that a soft reset keeps the lock closed. A design that cleared the lock, or accepted protected writes while locked, would show changed compare or status values. Busy flags are sampled on their last high cycle and on their first low cycle, which catches any off-by-one in the hold time. A disable that is never observed as "disabling" points to a missing 1-to-0 detection.

// File: rtl/tmrf_pkg.sv
// Package: shared window encoding, register identifiers and busy-slot
// indices for the timer register front end.
package tmrf_pkg;

    // Window selected by the top two address bits.
    typedef enum logic [1:0] {
        WIN_BASE = 2'd0,
        WIN_SET  = 2'd1,
        WIN_CLR  = 2'd2,
        WIN_TGL  = 2'd3
    } win_e;

    // Register identifiers (positions in the select vector).
    localparam int ID_VERSION = 0;
    localparam int ID_ENABLE  = 1;
    localparam int ID_SWRST   = 2;
    localparam int ID_LOCK    = 3;
    localparam int ID_STATUS  = 4;
    localparam int ID_CONFIG  = 5;
    localparam int ID_COMMAND = 6;
    localparam int ID_COUNT   = 7;
    localparam int ID_TOPBUSY = 8;
    localparam int ID_FLAGS   = 9;
    localparam int ID_FLAGEN  = 10;
    localparam int ID_GCTRL   = 11;
    localparam int ID_CMPA    = 12;
    localparam int ID_CMPB    = 13;
    localparam int ID_CAPTURE = 14;
    localparam int ID_GRPBUSY = 15;
    localparam int NREG       = 16;

    // Busy-timer slots.
    localparam int BZ_DISABLING = 0;
    localparam int BZ_RESETTING = 1;
    localparam int BZ_START     = 2;
    localparam int BZ_STOP      = 3;
    localparam int BZ_CNTWR     = 4;
    localparam int BZ_GCTRL     = 5;
    localparam int BZ_CMPA      = 6;
    localparam int BZ_CMPB      = 7;
    localparam int NBUSY        = 8;

    // Word index (byte offset / 4) of each register identifier.
    function automatic int word_of(input int id);
        case (id)
            ID_VERSION: return 0;
            ID_ENABLE:  return 1;
            ID_SWRST:   return 2;
            ID_LOCK:    return 3;
            ID_STATUS:  return 4;
            ID_CONFIG:  return 5;
            ID_COMMAND: return 6;
            ID_COUNT:   return 7;
            ID_TOPBUSY: return 8;
            ID_FLAGS:   return 16;
            ID_FLAGEN:  return 17;
            ID_GCTRL:   return 18;
            ID_CMPA:    return 19;
            ID_CMPB:    return 20;
            ID_CAPTURE: return 21;
            ID_GRPBUSY: return 22;
            default:    return 1023;
        endcase
    endfunction

endpackage

// File: rtl/tmrf_decode.sv
// Address decoder: splits a byte address into the alias window and a
// one-hot register select. Assumes the window lives in the top two
// address bits and that misaligned addresses select nothing.
module tmrf_decode
    import tmrf_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic [ADDR_W-1:0] addr,
    output win_e              win,
    output logic [NREG-1:0]   sel
);
    localparam int WBITS = ADDR_W - 4;

    logic [WBITS-1:0] word;
    logic             aligned;

    // Window and word fields.
    assign win     = win_e'(addr[ADDR_W-1 -: 2]);
    assign word    = addr[ADDR_W-3:2];
    assign aligned = (addr[1:0] == 2'b00);

    // One comparator per register identifier.
    for (genvar k = 0; k < NREG; k++) begin : g_sel
        assign sel[k] = aligned && (word == WBITS'(word_of(k)));
    end

endmodule

// File: rtl/tmrf_alias_alu.sv
// Alias arithmetic: combines the current read-back value of a register
// with the write data according to the window. Purely combinational.
module tmrf_alias_alu
    import tmrf_pkg::*;
#(
    parameter int DW = 32
) (
    input  win_e          op,
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] res
);
    // Select the write result for the window.
    always_comb begin
        case (op)
            WIN_SET: res = old_val | din;
            WIN_CLR: res = old_val & ~din;
            WIN_TGL: res = old_val ^ din;
            default: res = din;
        endcase
    end

endmodule

// File: rtl/tmrf_busy_timer.sv
// Busy hold timer: raises busy_o for HOLD cycles after trig_i; clr_i
// cancels a running hold, trig_i wins over clr_i. Assumes HOLD >= 1.
module tmrf_busy_timer #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic trig_i,
    output logic busy_o
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt_q;

    // Load, cancel or count down the hold counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (trig_i) begin
            cnt_q <= CW'(HOLD);
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign busy_o = (cnt_q != '0);

    // A busy flag only rises right after a trigger.
    assert_busy_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(trig_i));

    // A hold that is neither retriggered nor cancelled keeps going while count > 1.
    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > CW'(1) && !trig_i && !clr_i) |=> busy_o);

endmodule

// File: rtl/tmrf_regfront.sv
// Timer register front end: address decode with set/clear/toggle alias
// windows, key-guarded configuration, enable and soft-reset sequencing,
// and per-register busy flags. Assumes one access per cycle with
// combinational read data; the counter datapath is external.
module tmrf_regfront
    import tmrf_pkg::*;
#(
    parameter int          ADDR_W     = 14,
    parameter int          DW         = 32,
    parameter int          CFG_W      = 1,
    parameter int          CTRL_W     = 11,
    parameter int          FLAG_W     = 4,
    parameter int          KEY_W      = 16,
    parameter int          BUSY_CYC   = 4,
    parameter int          VERSION    = 1,
    parameter logic [15:0] UNLOCK_KEY = 16'h4776
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [DW-1:0]     cnt_value_i,
    input  logic [DW-1:0]     cap_value_i,
    input  logic              running_i,
    input  logic [FLAG_W-1:0] evt_i,
    output logic              mod_en_o,
    output logic [CFG_W-1:0]  config_o,
    output logic [CTRL_W-1:0] grp_ctrl_o,
    output logic [DW-1:0]     cmpa_o,
    output logic [DW-1:0]     cmpb_o,
    output logic              start_pulse_o,
    output logic              stop_pulse_o,
    output logic              cnt_load_o,
    output logic [DW-1:0]     cnt_load_data_o,
    output logic              irq_o
);
    localparam logic [KEY_W-1:0] KEY = KEY_W'(UNLOCK_KEY);

    win_e              win;
    logic [NREG-1:0]   sel;
    logic [NREG-1:0]   wsel;
    logic [DW-1:0]     rd_val;
    logic [DW-1:0]     wr_val;
    logic [NBUSY-1:0]  trig;
    logic [NBUSY-1:0]  busy;
    logic              prot_ok;
    logic              swrst_fire;

    logic              en_q;
    logic              locked_q;
    logic [CFG_W-1:0]  cfg_q;
    logic [CTRL_W-1:0] gctrl_q;
    logic [DW-1:0]     cmpa_q;
    logic [DW-1:0]     cmpb_q;
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] flagen_q;
    logic              start_q;
    logic              stop_q;
    logic              load_q;
    logic [DW-1:0]     load_data_q;

    tmrf_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .win  (win),
        .sel  (sel)
    );

    // Read-back mux; also the "old" operand of the alias arithmetic.
    always_comb begin
        rd_val = '0;
        if (sel[ID_VERSION]) rd_val = DW'(VERSION);
        if (sel[ID_ENABLE])  rd_val = DW'({busy[BZ_DISABLING], en_q});
        if (sel[ID_SWRST])   rd_val = DW'({busy[BZ_RESETTING], 1'b0});
        if (sel[ID_STATUS])  rd_val = DW'({locked_q, running_i});
        if (sel[ID_CONFIG])  rd_val = DW'(cfg_q);
        if (sel[ID_COUNT])   rd_val = cnt_value_i;
        if (sel[ID_TOPBUSY]) rd_val = DW'({busy[BZ_CNTWR], busy[BZ_STOP], busy[BZ_START]});
        if (sel[ID_FLAGS])   rd_val = DW'(flags_q);
        if (sel[ID_FLAGEN])  rd_val = DW'(flagen_q);
        if (sel[ID_GCTRL])   rd_val = DW'(gctrl_q);
        if (sel[ID_CMPA])    rd_val = cmpa_q;
        if (sel[ID_CMPB])    rd_val = cmpb_q;
        if (sel[ID_CAPTURE]) rd_val = cap_value_i;
        if (sel[ID_GRPBUSY]) rd_val = DW'({busy[BZ_CMPB], busy[BZ_CMPA], busy[BZ_GCTRL]});
    end

    assign bus_rdata = rd_val;

    tmrf_alias_alu #(.DW(DW)) u_alu (
        .op      (win),
        .old_val (rd_val),
        .din     (bus_wdata),
        .res     (wr_val)
    );

    // Write qualification.
    assign wsel       = bus_wr ? sel : '0;
    assign prot_ok    = !locked_q;
    assign swrst_fire = wsel[ID_SWRST] && wr_val[0];

    // Busy trigger sources, one per slot.
    always_comb begin
        trig               = '0;
        trig[BZ_DISABLING] = wsel[ID_ENABLE] && en_q && !wr_val[0];
        trig[BZ_RESETTING] = swrst_fire;
        trig[BZ_START]     = wsel[ID_COMMAND] && wr_val[0];
        trig[BZ_STOP]      = wsel[ID_COMMAND] && wr_val[1];
        trig[BZ_CNTWR]     = wsel[ID_COUNT] && prot_ok;
        trig[BZ_GCTRL]     = wsel[ID_GCTRL] && prot_ok;
        trig[BZ_CMPA]      = wsel[ID_CMPA] && prot_ok;
        trig[BZ_CMPB]      = wsel[ID_CMPB] && prot_ok;
    end

    // One hold timer per busy slot; soft reset cancels all but its own.
    for (genvar k = 0; k < NBUSY; k++) begin : g_busy
        logic clr_k;
        if (k == BZ_RESETTING) begin : g_self
            assign clr_k = 1'b0;
        end else begin : g_other
            assign clr_k = swrst_fire;
        end
        tmrf_busy_timer #(.HOLD(BUSY_CYC)) u_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (clr_k),
            .trig_i (trig[k]),
            .busy_o (busy[k])
        );
    end

    // Module enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n || swrst_fire) en_q <= 1'b0;
        else if (wsel[ID_ENABLE]) en_q <= wr_val[0];
    end

    // Lock state: survives soft reset, follows the last key written.
    always_ff @(posedge clk) begin
        if (!rst_n) locked_q <= 1'b0;
        else if (wsel[ID_LOCK]) locked_q <= (wr_val[KEY_W-1:0] != KEY);
    end

    // Protected configuration bit.
    always_ff @(posedge clk) begin
        if (!rst_n || swrst_fire) cfg_q <= '0;
        else if (wsel[ID_CONFIG] && prot_ok) cfg_q <= wr_val[CFG_W-1:0];
    end

    // Protected group control field.
    always_ff @(posedge clk) begin
        if (!rst_n || swrst_fire) gctrl_q <= '0;
        else if (trig[BZ_GCTRL]) gctrl_q <= wr_val[CTRL_W-1:0];
    end

    // Protected compare A value.
    always_ff @(posedge clk) begin
        if (!rst_n || swrst_fire) cmpa_q <= '0;
        else if (trig[BZ_CMPA]) cmpa_q <= wr_val;
    end

    // Protected compare B value.
    always_ff @(posedge clk) begin
        if (!rst_n || swrst_fire) cmpb_q <= '0;
        else if (trig[BZ_CMPB]) cmpb_q <= wr_val;
    end

    // Interrupt flags: software write, then hardware events OR in.
    always_ff @(posedge clk) begin
        if (!rst_n || swrst_fire) flags_q <= '0;
        else flags_q <= (wsel[ID_FLAGS] ? wr_val[FLAG_W-1:0] : flags_q) | evt_i;
    end

    // Interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n || swrst_fire) flagen_q <= '0;
        else if (wsel[ID_FLAGEN]) flagen_q <= wr_val[FLAG_W-1:0];
    end

    // One-cycle command and counter-load pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q     <= 1'b0;
            stop_q      <= 1'b0;
            load_q      <= 1'b0;
            load_data_q <= '0;
        end else begin
            start_q <= trig[BZ_START];
            stop_q  <= trig[BZ_STOP];
            load_q  <= trig[BZ_CNTWR];
            if (trig[BZ_CNTWR]) load_data_q <= wr_val;
        end
    end

    assign mod_en_o        = en_q;
    assign config_o        = cfg_q;
    assign grp_ctrl_o      = gctrl_q;
    assign cmpa_o          = cmpa_q;
    assign cmpb_o          = cmpb_q;
    assign start_pulse_o   = start_q;
    assign stop_pulse_o    = stop_q;
    assign cnt_load_o      = load_q;
    assign cnt_load_data_o = load_data_q;
    assign irq_o           = |(flags_q & flagen_q);

    // The correct key written in the base window unlocks.
    assert_unlock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel[ID_LOCK] && win == WIN_BASE && bus_wdata[KEY_W-1:0] == KEY)
        |=> !locked_q);

    // Locked compare writes leave the output alone.
    assert_locked_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel[ID_CMPA] && locked_q) |=> $stable(cmpa_o));

    // Soft reset does not disturb the lock.
    assert_swrst_keeps_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_fire |=> $stable(locked_q));

    // A start pulse is always accompanied by its busy flag.
    assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse_o |-> busy[BZ_START]);

    // Events without a write always land in the flags.
    assert_evt_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && evt_i != '0) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

endmodule

// File: tb/tmrf_regfront_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus
// directed reads with hand-computed expectations.
module tmrf_regfront_tb_top;
    localparam int HOLD = 4;
    localparam logic [31:0] CNTV = 32'hC0FFEE00;
    localparam logic [31:0] CAPV = 32'h0BADF00D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [13:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        running_i = 1'b0;
    logic [3:0]  evt_i = '0;
    logic        mod_en_o;
    logic [0:0]  config_o;
    logic [10:0] grp_ctrl_o;
    logic [31:0] cmpa_o, cmpb_o, cnt_load_data_o;
    logic        start_pulse_o, stop_pulse_o, cnt_load_o, irq_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    tmrf_regfront #(.BUSY_CYC(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_value_i(CNTV),
        .cap_value_i(CAPV), .running_i(running_i), .evt_i(evt_i),
        .mod_en_o(mod_en_o), .config_o(config_o), .grp_ctrl_o(grp_ctrl_o),
        .cmpa_o(cmpa_o), .cmpb_o(cmpb_o), .start_pulse_o(start_pulse_o),
        .stop_pulse_o(stop_pulse_o), .cnt_load_o(cnt_load_o),
        .cnt_load_data_o(cnt_load_data_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state.
    logic        m_en, m_cfg, m_locked, m_start, m_stop, m_load, m_swr;
    logic [3:0]  m_flags, m_flagen;
    logic [10:0] m_gctrl;
    logic [31:0] m_cmpa, m_cmpb, m_ldata;
    int          m_dis, m_rs;
    int          m_bz[6];   // start, stop, count, gctrl, cmpa, cmpb

    function automatic logic [31:0] m_read(input logic [13:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (int'(a[11:2]))
            0:  return 32'd1;
            1:  return {30'b0, m_dis != 0, m_en};
            2:  return {30'b0, m_rs != 0, 1'b0};
            4:  return {30'b0, m_locked, running_i};
            5:  return {31'b0, m_cfg};
            7:  return CNTV;
            8:  return {29'b0, m_bz[2] != 0, m_bz[1] != 0, m_bz[0] != 0};
            16: return {28'b0, m_flags};
            17: return {28'b0, m_flagen};
            18: return {21'b0, m_gctrl};
            19: return m_cmpa;
            20: return m_cmpb;
            21: return CAPV;
            22: return {29'b0, m_bz[5] != 0, m_bz[4] != 0, m_bz[3] != 0};
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_clear_all();
        m_en = 0; m_cfg = 0; m_flags = 0; m_flagen = 0; m_gctrl = 0;
        m_cmpa = 0; m_cmpb = 0; m_dis = 0;
        for (int i = 0; i < 6; i++) m_bz[i] = 0;
    endtask

    task automatic m_write(input logic [13:0] a, input logic [31:0] d);
        logic [31:0] old, nv;
        old = m_read(a);
        case (a[13:12])
            2'd1:    nv = old | d;
            2'd2:    nv = old & ~d;
            2'd3:    nv = old ^ d;
            default: nv = d;
        endcase
        if (a[1:0] == 2'b00) begin
            case (int'(a[11:2]))
                1: begin if (m_en && !nv[0]) m_dis = HOLD; m_en = nv[0]; end
                2: if (nv[0]) begin m_clear_all(); m_rs = HOLD; m_swr = 1; end
                3: m_locked = (nv[15:0] != 16'h4776);
                5: if (!m_locked) m_cfg = nv[0];
                6: begin
                    if (nv[0]) begin m_start = 1; m_bz[0] = HOLD; end
                    if (nv[1]) begin m_stop = 1; m_bz[1] = HOLD; end
                end
                7: if (!m_locked) begin m_load = 1; m_ldata = nv; m_bz[2] = HOLD; end
                16: m_flags = nv[3:0];
                17: m_flagen = nv[3:0];
                18: if (!m_locked) begin m_gctrl = nv[10:0]; m_bz[3] = HOLD; end
                19: if (!m_locked) begin m_cmpa = nv; m_bz[4] = HOLD; end
                20: if (!m_locked) begin m_cmpb = nv; m_bz[5] = HOLD; end
                default: ;
            endcase
        end
    endtask

    // Model update at each edge, then lockstep compare a quarter period later.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_clear_all();
            m_locked = 0; m_rs = 0; m_start = 0; m_stop = 0; m_load = 0; m_ldata = 0;
        end else begin
            if (m_dis > 0) m_dis--;
            if (m_rs > 0) m_rs--;
            for (int i = 0; i < 6; i++) if (m_bz[i] > 0) m_bz[i]--;
            m_start = 0; m_stop = 0; m_load = 0; m_swr = 0;
            if (bus_wr) m_write(bus_addr, bus_wdata);
            if (!m_swr) m_flags = m_flags | evt_i;
        end
        #5;
        chk("R6 enable out", {31'b0, mod_en_o}, {31'b0, m_en});
        chk("R5 config out", {31'b0, config_o}, {31'b0, m_cfg});
        chk("R5 group ctrl out", {21'b0, grp_ctrl_o}, {21'b0, m_gctrl});
        chk("R5 compare A out", cmpa_o, m_cmpa);
        chk("R5 compare B out", cmpb_o, m_cmpb);
        chk("R8 start pulse", {31'b0, start_pulse_o}, {31'b0, m_start});
        chk("R8 stop pulse", {31'b0, stop_pulse_o}, {31'b0, m_stop});
        chk("R8 load pulse", {31'b0, cnt_load_o}, {31'b0, m_load});
        if (m_load) chk("R8 load data", cnt_load_data_o, m_ldata);
        chk("R10 irq", {31'b0, irq_o}, {31'b0, |(m_flags & m_flagen)});
        chk("R1 read data", bus_rdata, m_read(bus_addr));
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [13:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        // R11 reset state, R3 version
        rd(14'h000, 32'd1, "R11 R3 version after reset");
        rd(14'h04C, 32'h0, "R11 compare A after reset");
        rd(14'h010, 32'h0, "R11 status after reset");
        rd(14'h004, 32'h0, "R11 enable after reset");
        // R1 windows, R2 alias arithmetic
        wr(14'h04C, 32'h12345678);
        rd(14'h104C, 32'h12345678, "R1 read via set window");
        rd(14'h304C, 32'h12345678, "R1 read via toggle window");
        wr(14'h104C, 32'h0000000F);
        rd(14'h04C, 32'h1234567F, "R2 set alias");
        wr(14'h204C, 32'h000000F0);
        rd(14'h04C, 32'h1234560F, "R2 clear alias");
        wr(14'h304C, 32'hFFFF0000);
        rd(14'h04C, 32'hEDCB560F, "R2 toggle alias");
        wr(14'h04E, 32'h0);
        rd(14'h04C, 32'hEDCB560F, "R1 misaligned write ignored");
        rd(14'h0FC, 32'h0, "R1 unmapped reads zero");
        rd(14'h054, CAPV, "R1 capture read");
        // R3 version writes ignored
        wr(14'h000, 32'hFF); wr(14'h1000, 32'hFF); wr(14'h2000, 32'hFFFFFFFF); wr(14'h3000, 32'h1);
        rd(14'h000, 32'd1, "R3 version unchanged");
        // R4 lock, R5 protection
        wr(14'h00C, 32'h1);
        rd(14'h010, 32'h2, "R4 locked status");
        wr(14'h04C, 32'h0);
        rd(14'h04C, 32'hEDCB560F, "R5 compare write dropped");
        wr(14'h014, 32'h1);
        chk("R5 config write dropped", {31'b0, config_o}, 32'h0);
        wr(14'h01C, 32'h5);
        chk("R5 counter write dropped", {31'b0, cnt_load_o}, 32'h0);
        rd(14'h020, 32'h0, "R5 no busy while locked");
        wr(14'h00C, 32'h4776);
        rd(14'h010, 32'h0, "R4 unlocked status");
        running_i = 1;
        rd(14'h010, 32'h1, "R4 status running bit");
        running_i = 0;
        wr(14'h014, 32'h1);
        chk("R5 config accepted", {31'b0, config_o}, 32'h1);
        wr(14'h00C, 32'h4777);
        rd(14'h010, 32'h2, "R4 wrong key locks");
        wr(14'h300C, 32'h4776);
        rd(14'h010, 32'h0, "R4 key via toggle window");
        // R6 enable and disabling
        wr(14'h004, 32'h1);
        chk("R6 enable set", {31'b0, mod_en_o}, 32'h1);
        wr(14'h2004, 32'h1);
        chk("R6 enable cleared", {31'b0, mod_en_o}, 32'h0);
        rd(14'h004, 32'h2, "R6 disabling first cycle");
        idle(HOLD - 1);
        rd(14'h004, 32'h2, "R6 disabling last cycle");
        idle(1);
        rd(14'h004, 32'h0, "R6 disabling ends");
        // R8 commands and counter load
        wr(14'h1018, 32'h3);
        chk("R8 start pulse", {31'b0, start_pulse_o}, 32'h1);
        chk("R8 stop pulse", {31'b0, stop_pulse_o}, 32'h1);
        rd(14'h020, 32'h3, "R8 start/stop busy");
        rd(14'h018, 32'h0, "R8 command reads zero");
        idle(1);
        chk("R8 start pulse one cycle", {31'b0, start_pulse_o}, 32'h0);
        idle(HOLD);
        wr(14'h01C, 32'hA5);
        chk("R8 load strobe", {31'b0, cnt_load_o}, 32'h1);
        chk("R8 load value", cnt_load_data_o, 32'hA5);
        rd(14'h020, 32'h4, "R8 counter busy");
        idle(HOLD);
        rd(14'h020, 32'h0, "R8 busy clears");
        // R9 group busy
        wr(14'h048, 32'h7FF);
        rd(14'h058, 32'h1, "R9 control busy");
        rd(14'h048, 32'h7FF, "R9 control value");
        idle(HOLD);
        wr(14'h04C, 32'h1);
        rd(14'h058, 32'h2, "R9 compare A busy");
        idle(HOLD);
        wr(14'h050, 32'hCAFE);
        rd(14'h058, 32'h4, "R9 compare B busy");
        idle(HOLD);
        rd(14'h058, 32'h0, "R9 group busy clears");
        // R10 flags and interrupt
        @(negedge clk); evt_i = 4'b0101;
        @(negedge clk); evt_i = 4'b0000;
        rd(14'h040, 32'h5, "R10 events set flags");
        chk("R10 irq masked", {31'b0, irq_o}, 32'h0);
        wr(14'h044, 32'h1);
        chk("R10 irq enabled", {31'b0, irq_o}, 32'h1);
        wr(14'h2040, 32'h1);
        rd(14'h040, 32'h4, "R10 clear flag");
        chk("R10 irq drops", {31'b0, irq_o}, 32'h0);
        wr(14'h3040, 32'h3);
        rd(14'h040, 32'h7, "R10 toggle flags");
        chk("R10 irq again", {31'b0, irq_o}, 32'h1);
        // R7 soft reset keeps lock
        wr(14'h004, 32'h1);
        wr(14'h00C, 32'h0);
        wr(14'h2008, 32'h1);
        rd(14'h008, 32'h0, "R7 clear alias no reset");
        rd(14'h040, 32'h7, "R7 flags kept without reset");
        wr(14'h008, 32'h1);
        rd(14'h04C, 32'h0, "R7 compare cleared");
        rd(14'h040, 32'h0, "R7 flags cleared");
        rd(14'h014, 32'h0, "R7 config cleared");
        rd(14'h010, 32'h2, "R7 lock kept");
        chk("R7 enable cleared", {31'b0, mod_en_o}, 32'h0);
        rd(14'h008, 32'h2, "R7 resetting");
        idle(HOLD);
        rd(14'h008, 32'h0, "R7 resetting ends");
        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule